// File: doc/BRIEF.md
# Oscillator Start-Up and On-Demand Sequencer

This block decides when an external oscillator is powered and when its output may be treated as a usable clock. It runs entirely on a slow, always-on low-power clock. A global enable, an on-demand mode bit and a peripheral clock-request line together form the run condition. When the run condition holds, the block asserts the oscillator run output. It then waits a start-up period of 2^code slow-clock cycles, where the code is a 4-bit select, before it asserts ready.

With on-demand clear, the oscillator runs whenever enable is set. With on-demand set, it runs only while a peripheral is also requesting the clock. The request line arrives from another clock domain and passes through a two-stage synchronizer first. If the run condition is lost in any state, the oscillator stops, ready drops, and the next start repeats the whole wait. The start-up code is captured at the moment the wait begins.

Top module: `osc_startup_seq`

## Requirements
- R1: While reset is asserted, and on the first sampling after it, `osc_run` and `osc_ready` are both 0.
- R2: With `ondemand`=0, setting `en`=1 raises `osc_run` one clock edge later, whatever the value of `clk_req`.
- R3: Once `osc_run` rises, `osc_ready` rises after exactly 2^`startup_sel` further edges. For 2^`startup_sel`-1 edges `osc_ready` stays 0 and `osc_run` stays 1.
- R4: Code 0 gives a wait of 1 cycle, code 0xD gives 8192 cycles and code 0xF gives 32768 cycles.
- R5: With `ondemand`=1 and `en`=1, `osc_run` stays 0 while `clk_req` is 0. A `clk_req` rise raises `osc_run` on the third edge after it (two synchronizer stages plus the state register).
- R6: With `ondemand`=1, a synchronized `clk_req` of 0 clears `osc_run` and `osc_ready` on the next edge.
- R7: `en`=0 clears `osc_run` and `osc_ready` on the next edge from any state.
- R8: After the run condition is lost, a new start repeats the full 2^code wait.
- R9: `startup_sel` is captured on the edge where the wait begins. Later changes to it do not alter the wait in progress.
- R10: `osc_ready` is never 1 while `osc_run` is 0.
- R11: If the run condition is lost on the same edge where the wait would complete, the block goes to the stopped state and `osc_ready` does not rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Oscillator enable |
| ondemand | input | 1 | 1: run only while a peripheral requests the clock |
| clk_req | input | 1 | Peripheral clock request, asynchronous |
| startup_sel | input | 4 | Start-up code; wait is 2^code cycles |
| osc_run | output | 1 | Oscillator power/run control |
| osc_ready | output | 1 | Oscillator clock considered stable |

## Verification
The completion of the start-up count and the loss of the run condition can land on the same edge. Losing the run condition must take priority. A directed case provokes this by dropping `en` just before the edge on which the count would finish. The case passes only if `osc_ready` stays low and `osc_run` falls on that edge. Constrained random stimulus toggles enable, mode and request at short start-up codes, so many such collisions occur. Each cycle of that random run is compared against a bench model of the requirements.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_STARTING = 2'd1,
    ST_READY    = 2'd2
  } osc_state_e;
endpackage

// File: rtl/osc_req_sync.sv
// Multi-stage synchronizer for the asynchronous clock-request line.
module osc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], async_in};
  end

  assign sync_out = shreg[STAGES-1];
endmodule

// File: rtl/osc_wait_counter.sv
// Exponent-coded wait counter: loads a limit of 2^code on start,
// flags the final cycle of the wait.
module osc_wait_counter #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [SEL_W-1:0] code,
  output logic             last
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_m1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      limit_m1_q <= '0;
    end else if (load) begin
      count_q    <= '0;
      limit_m1_q <= (CNT_W'(1) << code) - CNT_W'(1);
    end else if (advance) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign last = (count_q == limit_m1_q);
endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq #(
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ondemand,
  input  logic             clk_req,
  input  logic [SEL_W-1:0] startup_sel,
  output logic             osc_run,
  output logic             osc_ready
);
  import osc_seq_pkg::*;

  logic       req_s;
  logic       run_cond;
  logic       wait_last;
  logic       cnt_load;
  logic       cnt_adv;
  osc_state_e state_q;
  osc_state_e state_d;

  osc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (clk_req),
    .sync_out (req_s)
  );

  assign run_cond = en & (~ondemand | req_s);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_adv  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (run_cond) begin
          state_d  = ST_STARTING;
          cnt_load = 1'b1;
        end
      end
      ST_STARTING: begin
        if (!run_cond)      state_d = ST_OFF;
        else if (wait_last) state_d = ST_READY;
        else                cnt_adv = 1'b1;
      end
      ST_READY: begin
        if (!run_cond) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  osc_wait_counter #(.SEL_W(SEL_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .advance (cnt_adv),
    .code    (startup_sel),
    .last    (wait_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      osc_run   <= 1'b0;
      osc_ready <= 1'b0;
    end else begin
      state_q   <= state_d;
      osc_run   <= (state_d != ST_OFF);
      osc_ready <= (state_d == ST_READY);
    end
  end
endmodule

// File: rtl/osc_startup_seq_chk.sv
module osc_startup_seq_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             ondemand,
  input logic             req_s,
  input logic [SEL_W-1:0] startup_sel,
  input logic             osc_run,
  input logic             osc_ready
);
  localparam int W = (1 << SEL_W) + 1;

  logic [SEL_W-1:0] sel_q;
  logic             run_q;
  logic [W-1:0]     lim_q;
  logic [W-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      run_q <= 1'b0;
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= startup_sel;
      run_q <= osc_run;
      if (osc_run && !run_q) begin
        lim_q <= W'(1) << sel_q;
        cnt_q <= W'(1);
      end else if (osc_run && !osc_ready) begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  // R10
  ready_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    osc_ready |-> osc_run);

  // R3
  wait_length_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_ready) |-> (cnt_q == lim_q));

  // R7
  disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!osc_run && !osc_ready));

  // R2
  always_on_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ondemand) |=> osc_run);

  // R6
  no_request_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (ondemand && !req_s) |=> !osc_run);
endmodule

bind osc_startup_seq osc_startup_seq_chk #(.SEL_W(SEL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .ondemand    (ondemand),
  .req_s       (req_s),
  .startup_sel (startup_sel),
  .osc_run     (osc_run),
  .osc_ready   (osc_ready)
);

// File: tb/osc_startup_seq_tb_top.sv
`timescale 1ns/1ps
module osc_startup_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       ondemand = 1'b0;
  logic       clk_req = 1'b0;
  logic [3:0] startup_sel = 4'd0;
  logic       osc_run;
  logic       osc_ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osc_startup_seq dut_i (
    .clk(clk), .rst(rst), .en(en), .ondemand(ondemand), .clk_req(clk_req),
    .startup_sel(startup_sel), .osc_run(osc_run), .osc_ready(osc_ready)
  );

  function automatic int wait_len(input logic [3:0] code);
    return 1 << code;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; ondemand = 1'b0; clk_req = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  // Start from OFF with ondemand clear, measure the wait for a code.
  task automatic measure(input logic [3:0] code, input string tag);
    int lim;
    lim = wait_len(code);
    startup_sel = code;
    en = 1'b1;
    step(1);
    check({tag, " run after enable"}, osc_run, 1'b1);
    check({tag, " ready low at start"}, osc_ready, 1'b0);
    if (lim > 1) begin
      step(lim - 1);
      check({tag, " ready low one cycle before end"}, osc_ready, 1'b0);
      check({tag, " run held during wait"}, osc_run, 1'b1);
    end
    step(1);
    check({tag, " ready at end of wait"}, osc_ready, 1'b1);
    en = 1'b0;
    step(1);
  endtask

  // Reference model state for the random phase
  logic m_r1, m_r2, m_run, m_ready;
  int   m_state, m_cnt, m_lim;

  task automatic model_edge();
    logic rc;
    rc = en & (~ondemand | m_r2);
    case (m_state)
      0: if (rc) begin m_state = 1; m_cnt = 0; m_lim = wait_len(startup_sel); end
      1: if (!rc) m_state = 0;
         else if (m_cnt == m_lim - 1) m_state = 2;
         else m_cnt++;
      default: if (!rc) m_state = 0;
    endcase
    m_r2 = m_r1;
    m_r1 = clk_req;
    m_run = (m_state != 0);
    m_ready = (m_state == 2);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c11));
    // R1: reset state
    step(1);
    check("R1 run in reset", osc_run, 1'b0);
    check("R1 ready in reset", osc_ready, 1'b0);
    rst = 1'b0;
    step(1);
    check("R1 run after reset", osc_run, 1'b0);
    check("R1 ready after reset", osc_ready, 1'b0);

    // R2 / R3 / R4: always-on mode, request ignored
    clk_req = 1'b0;
    measure(4'd0, "R4 code0");
    measure(4'd3, "R3 code3");
    clk_req = 1'b1;
    measure(4'd1, "R2 req ignored");
    clk_req = 1'b0;
    measure(4'hD, "R4 code13");
    measure(4'hF, "R4 code15");

    // R5: on-demand gating and synchronizer latency
    ondemand = 1'b1; en = 1'b1; startup_sel = 4'd2;
    step(5);
    check("R5 no run without request", osc_run, 1'b0);
    clk_req = 1'b1;
    step(2);
    check("R5 run not before third edge", osc_run, 1'b0);
    step(1);
    check("R5 run on third edge", osc_run, 1'b1);
    step(4);
    check("R5 ready after wait", osc_ready, 1'b1);

    // R6: request withdrawn stops oscillator (3 edges through sync)
    clk_req = 1'b0;
    step(2);
    check("R6 still running during sync", osc_run, 1'b1);
    step(1);
    check("R6 run cleared", osc_run, 1'b0);
    check("R6 ready cleared", osc_ready, 1'b0);

    // R8: restart repeats full wait; R9: sel captured at entry
    clk_req = 1'b1;
    step(3);
    check("R8 restarted", osc_run, 1'b1);
    startup_sel = 4'd9;          // R9: must not change the wait of 4
    step(3);
    check("R8 full wait repeated", osc_ready, 1'b0);
    step(1);
    check("R9 captured code used", osc_ready, 1'b1);
    step(1);
    check("R9 ready held after code change", osc_ready, 1'b1);

    // R7: en low from READY
    en = 1'b0;
    step(1);
    check("R7 run cleared from ready", osc_run, 1'b0);
    check("R7 ready cleared from ready", osc_ready, 1'b0);

    // R11: run lost on completing edge
    ondemand = 1'b0; startup_sel = 4'd2; en = 1'b1;
    step(1);
    step(3);
    check("R11 ready low before collision", osc_ready, 1'b0);
    en = 1'b0;
    step(1);
    check("R11 ready not raised", osc_ready, 1'b0);
    check("R11 run dropped", osc_run, 1'b0);
    step(1);
    check("R11 ready stays low", osc_ready, 1'b0);

    // Random phase: R2 R3 R5 R6 R7 R8 R10 against model
    do_reset();
    m_r1 = 0; m_r2 = 0; m_state = 0; m_cnt = 0; m_lim = 1; m_run = 0; m_ready = 0;
    for (int i = 0; i < 3000; i++) begin
      en          = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 31) == 0) ondemand = ~ondemand;
      if ($urandom_range(0, 5) == 0)  clk_req  = ~clk_req;
      startup_sel = 4'($urandom_range(0, 3));
      model_edge();
      step(1);
      check("R3/R5/R6 random run", osc_run, m_run);
      check("R3/R10 random ready", osc_ready, m_ready);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule